// File: doc/BRIEF.md
# Byte-Residue Capturing Device-to-Memory Packer

This block sits on the device-to-memory side of a DMA channel whose memory port takes only aligned 4-byte words. It receives a byte stream from the device and packs each byte into its lane of the word at the current address. A byte whose address has offset k goes into bits [8k+7:8k]. Complete words go out as single aligned writes.

Partial words are never written. If the start address is unaligned, the bytes of the first word are diverted into a head-residue register. If the transfer stops part-way through a word, the bytes gathered so far go into a tail-residue register, and the current-address output is left pointing at the word still owed those bytes. Software later merges both residues into memory.

Each residue register packs a per-byte valid mask together with three data bytes. The head register keeps its mask in the low byte. The tail register keeps its mask in the high byte.

Top module: `byteres_dma`

## Requirements
- R1: A start pulse loads the current address with the start address rounded down to a multiple of 4. It sets busy and clears both residue registers to zero. All of this is visible on the cycle after the pulse.
- R2: Accepted bytes fill lanes in rising address order, byte lane k in data bits [8k+7:8k]. On the cycle after the byte that fills lane 3, a full word is written with `mem_we_o` high and `mem_addr_o` equal to the word's aligned address. The current address then advances by 4.
- R3: With start lane L in 1..3, the first word is not written once lane 3 fills. Instead the head register captures it:
  - bits [7:0] form a mask whose bit i is set when i+1 >= L;
  - data byte i, in bits [8i+15:8i+8], holds lane i+1 when its mask bit is set, and zero otherwise.
  - With an aligned start, the head register stays zero.
- R4: On a stop with lanes 0..2 partly filled, those bytes are not written. The tail register captures them:
  - bits [31:24] form a mask whose bit i is set when lane i holds a byte;
  - data byte i, in bits [8i+7:8i], holds lane i, and zero where no byte is present.
  - The current address stays at that word. If the stop lands on a word boundary, the tail register stays zero.
- R5: A byte presented together with stop is accepted before the tail is captured. If it completes a word, that word is written and the tail is zero. Busy falls on the cycle after the stop.
- R6: While idle, byte inputs cause no write and leave the current address unchanged, and stop leaves the tail register unchanged.
- R7: A start while busy restarts the transfer at the new address. A start takes priority over a stop in the same cycle, and a byte presented in the start cycle is dropped.
- R8: While reset is asserted, all outputs are zero.
- R9: If the stop comes before the first unaligned word fills, the head register stays zero. The tail register holds the gathered bytes in their own lanes, with mask bits only for lanes from L up to the last filled lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a transfer at start_addr_i |
| start_addr_i | input | ADDR_W | Byte address of the first byte |
| byte_valid_i | input | 1 | A device byte is presented |
| byte_i | input | 8 | Device byte |
| stop_i | input | 1 | End of transfer; capture the tail |
| mem_we_o | output | 1 | Full-word memory write strobe |
| mem_addr_o | output | ADDR_W | Aligned address of the written word |
| mem_data_o | output | 32 | Written word, lane k in bits [8k+7:8k] |
| head_res_o | output | 32 | Head residue: mask [7:0], data bytes [31:8] |
| tail_res_o | output | 32 | Tail residue: mask [31:24], data bytes [23:0] |
| cur_addr_o | output | ADDR_W | Aligned address of the word being assembled |
| busy_o | output | 1 | Transfer in progress |

## Verification
The bench builds the block with ADDR_W set to 16 and runs transfers based at 0x100 and 0x204. This covers every start lane from 0 to 3 and every tail length from zero to three bytes. Cases where a single word is both the head word and the tail word are included. Directed tests cover several collisions: a byte arriving together with stop, a start arriving together with stop and a byte, and bytes and stop arriving while the block is idle.

// File: rtl/byteres_pkg.sv
package byteres_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = $clog2(LANES);
  localparam int FILL_W = LANE_W + 1;
  localparam int RES_BYTES = LANES - 1;
  typedef logic [7:0] byte_t;
  typedef logic [LANES-1:0][7:0] word_t;
endpackage

// File: rtl/byteres_packer.sv
module byteres_packer
  import byteres_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [LANE_W-1:0] load_lane_i,
  input  logic              accept_i,
  input  byte_t             byte_i,
  output word_t             merged_o,
  output logic [LANE_W-1:0] first_lane_o,
  output logic [FILL_W-1:0] fill_o,
  output logic              done_o
);
  logic [LANE_W-1:0] lane_q, first_q;
  word_t             buf_q;

  always_comb begin
    merged_o = buf_q;
    if (accept_i) merged_o[lane_q] = byte_i;
    done_o = accept_i && (lane_q == LANE_W'(LANES - 1));
    fill_o = {1'b0, lane_q} + FILL_W'(accept_i);
  end

  assign first_lane_o = first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lane_q  <= '0;
      first_q <= '0;
      buf_q   <= '0;
    end else if (load_i) begin
      lane_q  <= load_lane_i;
      first_q <= load_lane_i;
      buf_q   <= '0;
    end else if (accept_i) begin
      if (done_o) begin
        lane_q  <= '0;
        first_q <= '0;
        buf_q   <= '0;
      end else begin
        lane_q <= lane_q + LANE_W'(1);
        buf_q  <= merged_o;
      end
    end
  end
endmodule

// File: rtl/byteres_residue.sv
module byteres_residue
  import byteres_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              head_en_i,
  input  logic              tail_en_i,
  input  logic              done_i,
  input  word_t             word_i,
  input  logic [LANE_W-1:0] first_lane_i,
  input  logic [FILL_W-1:0] fill_i,
  output logic [31:0]       head_o,
  output logic [31:0]       tail_o
);
  logic [RES_BYTES-1:0]      head_mask, tail_mask;
  logic [RES_BYTES-1:0][7:0] head_data, tail_data;
  logic [31:0]               head_q, tail_q;

  for (genvar i = 0; i < RES_BYTES; i++) begin : g_lane
    localparam logic [FILL_W-1:0] IDX = FILL_W'(i);
    // head byte i comes from lane i+1; tail byte i from lane i
    assign head_mask[i] = (IDX + FILL_W'(1)) >= {1'b0, first_lane_i};
    assign tail_mask[i] = (IDX >= {1'b0, first_lane_i}) && (IDX < fill_i) && !done_i;
    assign head_data[i] = head_mask[i] ? word_i[i+1] : 8'h00;
    assign tail_data[i] = tail_mask[i] ? word_i[i]   : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else if (clear_i) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (head_en_i) head_q <= {head_data, 5'b0, head_mask};
      if (tail_en_i) tail_q <= {5'b0, tail_mask, tail_data};
    end
  end

  assign head_o = head_q;
  assign tail_o = tail_q;
endmodule

// File: rtl/byteres_writer.sv
module byteres_writer
  import byteres_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_addr_i,
  input  logic              done_i,
  input  logic              skip_i,
  input  word_t             word_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_data_o,
  output logic [ADDR_W-1:0] cur_addr_o
);
  localparam int WIDX_W = ADDR_W - LANE_W;

  logic [WIDX_W-1:0] widx_q, wr_idx_q;
  logic              we_q;
  logic [31:0]       data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      widx_q   <= '0;
      wr_idx_q <= '0;
      we_q     <= 1'b0;
      data_q   <= '0;
    end else if (load_i) begin
      widx_q <= load_addr_i[ADDR_W-1:LANE_W];
      we_q   <= 1'b0;
    end else begin
      we_q <= done_i && !skip_i;
      if (done_i) begin
        widx_q <= widx_q + WIDX_W'(1);
        if (!skip_i) begin
          wr_idx_q <= widx_q;
          data_q   <= word_i;
        end
      end
    end
  end

  assign mem_we_o   = we_q;
  assign mem_addr_o = {wr_idx_q, {LANE_W{1'b0}}};
  assign mem_data_o = data_q;
  assign cur_addr_o = {widx_q, {LANE_W{1'b0}}};
endmodule

// File: rtl/byteres_dma.sv
module byteres_dma
  import byteres_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  input  logic              stop_i,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_data_o,
  output logic [31:0]       head_res_o,
  output logic [31:0]       tail_res_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              busy_o
);
  logic              busy_q, accept, stop_take, done, head_word;
  word_t             merged;
  logic [LANE_W-1:0] first_lane;
  logic [FILL_W-1:0] fill;

  assign accept    = byte_valid_i && busy_q && !start_i;
  assign stop_take = stop_i && busy_q && !start_i;
  assign head_word = first_lane != '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        busy_q <= 1'b0;
    else if (start_i)   busy_q <= 1'b1;
    else if (stop_take) busy_q <= 1'b0;
  end

  byteres_packer u_packer (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .load_i       (start_i),
    .load_lane_i  (start_addr_i[LANE_W-1:0]),
    .accept_i     (accept),
    .byte_i       (byte_i),
    .merged_o     (merged),
    .first_lane_o (first_lane),
    .fill_o       (fill),
    .done_o       (done)
  );

  byteres_residue u_residue (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .clear_i      (start_i),
    .head_en_i    (done && head_word),
    .tail_en_i    (stop_take),
    .done_i       (done),
    .word_i       (merged),
    .first_lane_i (first_lane),
    .fill_i       (fill),
    .head_o       (head_res_o),
    .tail_o       (tail_res_o)
  );

  byteres_writer #(.ADDR_W(ADDR_W)) u_writer (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start_i),
    .load_addr_i (start_addr_i),
    .done_i      (done),
    .skip_i      (head_word),
    .word_i      (merged),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_data_o  (mem_data_o),
    .cur_addr_o  (cur_addr_o)
  );

  assign busy_o = busy_q;
endmodule

// File: rtl/byteres_dma_chk.sv
module byteres_dma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [ADDR_W-1:0] start_addr_i,
  input logic              stop_i,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [ADDR_W-1:0] cur_addr_o,
  input logic [31:0]       head_res_o,
  input logic [31:0]       tail_res_o,
  input logic              busy_o
);
  AST_START_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i) |-> (cur_addr_o == ($past(start_addr_i) & ~ADDR_W'(3))) && busy_o
                       && head_res_o == '0 && tail_res_o == '0); // R1
  AST_WRITE_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> cur_addr_o == mem_addr_o + ADDR_W'(4)); // R2
  AST_HEAD_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    head_res_o[7:0] == 8'h00 || head_res_o[7:0] == 8'h04 ||
    head_res_o[7:0] == 8'h06 || head_res_o[7:0] == 8'h07); // R3
  AST_TAIL_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tail_res_o[31:27] == 5'b0 && tail_res_o[26:24] != 3'b101); // R4
  AST_STOP_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stop_i && !start_i) |-> !busy_o); // R5
  AST_NO_IDLE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(busy_o) |-> !mem_we_o); // R6
  AST_IDLE_TAIL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !$past(busy_o) && !$past(start_i)) |-> $stable(tail_res_o)); // R6
endmodule

bind byteres_dma byteres_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .start_addr_i (start_addr_i),
  .stop_i       (stop_i),
  .mem_we_o     (mem_we_o),
  .mem_addr_o   (mem_addr_o),
  .cur_addr_o   (cur_addr_o),
  .head_res_o   (head_res_o),
  .tail_res_o   (tail_res_o),
  .busy_o       (busy_o)
);

// File: tb/byteres_dma_bench.sv
`timescale 1ns/1ps
module byteres_dma_bench;
  localparam int AW = 16;

  typedef struct packed {
    logic [1:0]    lane;
    logic [3:0]    nbytes;
    logic [31:0]   head;
    logic [31:0]   tail;
    logic [3:0]    wcnt;
    logic [AW-1:0] last_addr;
    logic [31:0]   last_data;
    logic [AW-1:0] cur;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 4'd8, 32'h0, 32'h0, 4'd2, 16'h0104, 32'h17161514, 16'h0108},
    '{2'd0, 4'd0, 32'h0, 32'h0, 4'd0, 16'h0000, 32'h0,        16'h0100},
    '{2'd1, 4'd6, 32'h12111007, 32'h07151413, 4'd0, 16'h0000, 32'h0, 16'h0104},
    '{2'd2, 4'd2, 32'h11100006, 32'h0, 4'd0, 16'h0000, 32'h0, 16'h0104},
    '{2'd3, 4'd6, 32'h10000004, 32'h01000015, 4'd1, 16'h0104, 32'h14131211, 16'h0108},
    '{2'd1, 4'd2, 32'h0, 32'h06111000, 4'd0, 16'h0000, 32'h0, 16'h0100},
    '{2'd0, 4'd3, 32'h0, 32'h07121110, 4'd0, 16'h0000, 32'h0, 16'h0100}
  };

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [AW-1:0] start_addr_i = '0;
  logic          byte_valid_i = 1'b0;
  logic [7:0]    byte_i = '0;
  logic          stop_i = 1'b0;
  logic          mem_we_o;
  logic [AW-1:0] mem_addr_o;
  logic [31:0]   mem_data_o, head_res_o, tail_res_o;
  logic [AW-1:0] cur_addr_o;
  logic          busy_o;

  int tests = 0, fails = 0, wr_total = 0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  bit done_flag = 0;

  always #5 clk_i = ~clk_i;

  byteres_dma #(.ADDR_W(AW)) u_byteres_dma (.*);

  always @(negedge clk_i) begin
    if (mem_we_o) begin
      wr_total = wr_total + 1;
      wr_addr  = mem_addr_o;
      wr_data  = mem_data_o;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic begin_xfer(input logic [AW-1:0] addr);
    @(negedge clk_i);
    start_i = 1'b1; start_addr_i = addr;
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    byte_valid_i = 1'b1; byte_i = b;
    @(negedge clk_i);
    byte_valid_i = 1'b0;
  endtask

  task automatic end_xfer();
    stop_i = 1'b1;
    @(negedge clk_i);
    stop_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    tests++; fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    int base;
    logic [31:0] tail_hold;
    repeat (3) @(negedge clk_i);
    // R8 reset state
    check("R8 busy", 32'(busy_o), 32'h0);
    check("R8 we", 32'(mem_we_o), 32'h0);
    check("R8 cur", 32'(cur_addr_o), 32'h0);
    check("R8 head", head_res_o, 32'h0);
    check("R8 tail", tail_res_o, 32'h0);
    rst_ni = 1'b1;

    // vector table: R2 R3 R4 R9
    for (int v = 0; v < NV; v++) begin
      base = wr_total;
      begin_xfer(16'h0100 + AW'(VECS[v].lane));
      check("R1 busy after start", 32'(busy_o), 32'h1);
      check("R1 cleared residues", head_res_o | tail_res_o, 32'h0);
      for (int k = 0; k < int'(VECS[v].nbytes); k++) push(8'h10 + 8'(k));
      end_xfer();
      check("R3 head", head_res_o, VECS[v].head);
      check("R4 tail", tail_res_o, VECS[v].tail);
      check("R2 write count", 32'(wr_total - base), 32'(VECS[v].wcnt));
      if (VECS[v].wcnt != 0) begin
        check("R2 write addr", 32'(wr_addr), 32'(VECS[v].last_addr));
        check("R2 write data", wr_data, VECS[v].last_data);
      end
      check("R4 cur addr", 32'(cur_addr_o), 32'(VECS[v].cur));
      check("R5 busy cleared", 32'(busy_o), 32'h0);
    end

    // R6: idle bytes and stop ignored
    base = wr_total;
    tail_hold = tail_res_o;
    for (int k = 0; k < 5; k++) push(8'h99);
    end_xfer();
    check("R6 no idle write", 32'(wr_total - base), 32'h0);
    check("R6 cur unchanged", 32'(cur_addr_o), 32'h0100);
    check("R6 tail unchanged", tail_res_o, tail_hold);

    // R5: byte with stop completes word
    base = wr_total;
    begin_xfer(16'h0100);
    push(8'h10); push(8'h11); push(8'h12);
    byte_valid_i = 1'b1; byte_i = 8'h13; stop_i = 1'b1;
    @(negedge clk_i);
    byte_valid_i = 1'b0; stop_i = 1'b0;
    check("R5 we next cycle", 32'(mem_we_o), 32'h1);
    check("R5 data", mem_data_o, 32'h13121110);
    check("R5 addr", 32'(mem_addr_o), 32'h0100);
    check("R5 tail zero", tail_res_o, 32'h0);
    check("R5 cur", 32'(cur_addr_o), 32'h0104);
    check("R5 not busy", 32'(busy_o), 32'h0);

    // R7: restart while busy, start beats stop and byte
    begin_xfer(16'h0100);
    push(8'h10); push(8'h11);
    start_i = 1'b1; start_addr_i = 16'h0204; stop_i = 1'b1;
    byte_valid_i = 1'b1; byte_i = 8'hEE;
    @(negedge clk_i);
    start_i = 1'b0; stop_i = 1'b0; byte_valid_i = 1'b0;
    check("R7 busy kept", 32'(busy_o), 32'h1);
    check("R7 cur restart", 32'(cur_addr_o), 32'h0204);
    base = wr_total;
    for (int k = 0; k < 4; k++) push(8'h20 + 8'(k));
    end_xfer();
    check("R7 one write", 32'(wr_total - base), 32'h1);
    check("R7 data", wr_data, 32'h23222120);
    check("R7 addr", 32'(wr_addr), 32'h0204);
    check("R7 head zero", head_res_o, 32'h0);
    check("R7 cur", 32'(cur_addr_o), 32'h0208);

    finish_run();
  end
endmodule